// File: doc/BRIEF.md
# Signed Pulse-Stream Halving Adder

This block combines two signed, rate-coded pulse streams. Each operand is a sign wire plus a magnitude wire. The magnitude wire carries pulses grouped in fixed blocks of `SLOTS` clock cycles, and the operand's value is the fraction of slots in a block that hold a pulse. The block decides whether an add or subtract request reduces to adding magnitudes. It produces the result sign for that case and a merged pulse stream whose rate is half the sum of the two operand rates. A counter downstream integrates that stream.

No binary adder is used. An internal slot timer splits time into pairs of blocks. In the first block of a pair, operand A is sampled in odd slots and operand B in even slots. In the second block the roles swap. Every input pulse is therefore seen in exactly one of the two blocks' matching parities, so each operand contributes half of its pulses per block on average. The merged stream carries (A+B)/2 and cannot overflow.

The output pulses are not packed to the start of a block. The downstream counter must count scattered pulses. The magnitude-difference path and the final averaging sit outside this block.

Top module: `pstream_half_adder`

## Requirements
- R1: `add_en` is high exactly when (`mode_add` is high and `a_sign` equals `b_sign`) or (`mode_sub` is high and `a_sign` differs from `b_sign`); it responds combinationally in the same cycle.
- R2: While `add_en` is high, `res_sign` equals `a_sign`; while `add_en` is low, `res_sign` is 0.
- R3: While `add_en` is low, `sum_pulse` is 0 whatever the pulse inputs carry.
- R4: The first clock cycle after `rst_n` is released is slot 1 of the first block of a pair. Slots run 1..`SLOTS` within a block, and blocks alternate first/second of a pair.
- R5: In the first block of a pair, `sum_pulse` copies `a_pulse` in odd slots (1, 3, ...) and `b_pulse` in even slots (2, 4, ...), when enabled.
- R6: In the second block of a pair, `sum_pulse` copies `b_pulse` in odd slots and `a_pulse` in even slots, when enabled.
- R7: With compacted magnitudes a and b (pulses in slots 1..a and 1..b of every block), the first block carries ceil(a/2)+floor(b/2) pulses, the second floor(a/2)+ceil(b/2), and the pair a+b: a rate of (A+B)/2.
- R8: A synchronous reset asserted mid-block returns the timer to slot 1 of the first block of a pair.
- R9: The output is not packed to the block start: a full-scale A with zero B yields pulses only in slots 1, 3, 5, 7, 9 of the first block and 2, 4, 6, 8, 10 of the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one slot per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_add | input | 1 | Add operation requested |
| mode_sub | input | 1 | Subtract operation requested |
| a_sign | input | 1 | Sign of operand A (1 = negative) |
| b_sign | input | 1 | Sign of operand B (1 = negative) |
| a_pulse | input | 1 | Magnitude pulse stream of operand A |
| b_pulse | input | 1 | Magnitude pulse stream of operand B |
| add_en | output | 1 | Magnitude-add path is in use |
| res_sign | output | 1 | Result sign while adding |
| sum_pulse | output | 1 | Merged stream at rate (A+B)/2 |

## Verification
A slot counter that drifts, or a pair phase that fails to flip, shows up first as wrong per-block pulse counts. Compacted operands with different odd and even halves (a=1, b=0) expose the fault within one block of 10 cycles. They also reveal it through the slot position of the very first pulse after reset. A phase that never swaps leaves the pair total at a+b only when a and b have matching parity, so the sweep over every pair of magnitudes catches it within one 20-cycle window. A wrong enable decode appears at once on `add_en` and as a zero or non-zero `sum_pulse` count.

// File: rtl/pha_pkg.sv
`timescale 1ns/1ps
// Shared types for the pulse-stream halving adder.
package pha_pkg;
    // Which operand owns the odd slots in the current block.
    typedef enum logic {
        PH_A_ODD = 1'b0,   // first block of a pair
        PH_B_ODD = 1'b1    // second block of a pair
    } pair_phase_e;
endpackage

// File: rtl/pha_slot_timer.sv
`timescale 1ns/1ps
// Slot timer: counts SLOTS cycles per block and flips the pair phase at
// each block boundary. Assumes SLOTS is even, so slot parity restarts at
// an odd slot on every block. Reset returns to slot 1 of a first block.
module pha_slot_timer
    import pha_pkg::*;
#(
    parameter int SLOTS  = 10,
    parameter int SLOT_W = $clog2(SLOTS)
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic        odd_slot,
    output logic        last_slot,
    output pair_phase_e phase
);
    localparam logic [SLOT_W-1:0] LAST_IDX = SLOT_W'(SLOTS - 1);

    logic [SLOT_W-1:0] slot_idx;

    // Index 0 is slot 1 (odd), so the LSB low marks odd slots.
    always_comb begin
        odd_slot  = ~slot_idx[0];
        last_slot = (slot_idx == LAST_IDX);
    end

    // Advance the slot index and swap the pair phase on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_idx <= '0;
            phase    <= PH_A_ODD;
        end else if (last_slot) begin
            slot_idx <= '0;
            phase    <= (phase == PH_A_ODD) ? PH_B_ODD : PH_A_ODD;
        end else begin
            slot_idx <= slot_idx + 1'b1;
        end
    end
endmodule

// File: rtl/pha_sign_decode.sv
`timescale 1ns/1ps
// Sign decode: decides whether the request reduces to a magnitude add and
// gives the result sign for that case. Purely combinational.
module pha_sign_decode (
    input  logic mode_add,
    input  logic mode_sub,
    input  logic a_sign,
    input  logic b_sign,
    output logic add_en,
    output logic res_sign
);
    logic same_sign;

    // Enable on like signs for add, unlike signs for subtract.
    always_comb begin
        same_sign = ~(a_sign ^ b_sign);
        add_en    = (mode_add & same_sign) | (mode_sub & ~same_sign);
        res_sign  = add_en & a_sign;
    end
endmodule

// File: rtl/pha_slot_gate.sv
`timescale 1ns/1ps
// Slot gate: picks which operand's pulse passes in the current slot.
// The odd-slot owner is set by the pair phase; the other operand owns
// the even slots. Output is held low when the add path is disabled.
module pha_slot_gate
    import pha_pkg::*;
(
    input  logic        odd_slot,
    input  pair_phase_e phase,
    input  logic        add_en,
    input  logic        a_pulse,
    input  logic        b_pulse,
    output logic        sum_pulse
);
    logic take_a;

    // A is taken in odd slots of the first block and even slots of the second.
    always_comb begin
        take_a    = odd_slot ^ (phase == PH_B_ODD);
        sum_pulse = add_en & (take_a ? a_pulse : b_pulse);
    end
endmodule

// File: rtl/pstream_half_adder.sv
`timescale 1ns/1ps
// Signed pulse-stream halving adder. Merges two rate-coded magnitude
// streams into one stream at (A+B)/2 by alternating odd/even slot
// ownership across a pair of blocks. Assumes compact-or-scattered input
// pulses, one slot per clock, and an even SLOTS.
module pstream_half_adder
    import pha_pkg::*;
#(
    parameter int SLOTS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_add,
    input  logic mode_sub,
    input  logic a_sign,
    input  logic b_sign,
    input  logic a_pulse,
    input  logic b_pulse,
    output logic add_en,
    output logic res_sign,
    output logic sum_pulse
);
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    logic        odd_slot;
    logic        last_slot;
    pair_phase_e phase;

    // Slot and pair-phase sequencing.
    pha_slot_timer #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .odd_slot  (odd_slot),
        .last_slot (last_slot),
        .phase     (phase)
    );

    // Enable and sign selection.
    pha_sign_decode u_sign (
        .mode_add (mode_add),
        .mode_sub (mode_sub),
        .a_sign   (a_sign),
        .b_sign   (b_sign),
        .add_en   (add_en),
        .res_sign (res_sign)
    );

    // Per-slot operand selection.
    pha_slot_gate u_gate (
        .odd_slot  (odd_slot),
        .phase     (phase),
        .add_en    (add_en),
        .a_pulse   (a_pulse),
        .b_pulse   (b_pulse),
        .sum_pulse (sum_pulse)
    );
endmodule

// File: rtl/pha_chk.sv
`timescale 1ns/1ps
// Checker for pstream_half_adder: relates the decode, the gate and the
// slot timer over time. Bound to every instance of the top module.
module pha_chk
    import pha_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        mode_add,
    input logic        mode_sub,
    input logic        a_sign,
    input logic        b_sign,
    input logic        a_pulse,
    input logic        b_pulse,
    input logic        add_en,
    input logic        res_sign,
    input logic        sum_pulse,
    input logic        odd_slot,
    input logic        last_slot,
    input pair_phase_e phase
);
    // R1
    add_like_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_add && (a_sign == b_sign)) |-> add_en);

    // R1
    idle_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_add && !mode_sub) |-> !add_en);

    // R2
    sign_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        add_en |-> (res_sign == a_sign));

    // R3
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !add_en |-> !sum_pulse);

    // R4
    phase_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_slot |=> (phase != $past(phase)) && odd_slot);

    // R4
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !last_slot |=> $stable(phase) && (odd_slot != $past(odd_slot)));

    // R5
    source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sum_pulse |-> (a_pulse || b_pulse));
endmodule

bind pstream_half_adder pha_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_add  (mode_add),
    .mode_sub  (mode_sub),
    .a_sign    (a_sign),
    .b_sign    (b_sign),
    .a_pulse   (a_pulse),
    .b_pulse   (b_pulse),
    .add_en    (add_en),
    .res_sign  (res_sign),
    .sum_pulse (sum_pulse),
    .odd_slot  (odd_slot),
    .last_slot (last_slot),
    .phase     (phase)
);

// File: tb/pstream_half_adder_tb.sv
`timescale 1ns/1ps
// Directed bench: each task resets the block, drives one scenario from a
// falling edge and checks the outputs one time unit later.
module pstream_half_adder_tb;
    localparam int SLOTS = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_add = 1'b0, mode_sub = 1'b0;
    logic a_sign = 1'b0, b_sign = 1'b0;
    logic a_pulse = 1'b0, b_pulse = 1'b0;
    logic add_en, res_sign, sum_pulse;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    pstream_half_adder #(.SLOTS(SLOTS)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_add(mode_add), .mode_sub(mode_sub),
        .a_sign(a_sign), .b_sign(b_sign), .a_pulse(a_pulse), .b_pulse(b_pulse),
        .add_en(add_en), .res_sign(res_sign), .sum_pulse(sum_pulse)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Hold reset for two edges, release at a falling edge: slot 1 follows.
    task automatic do_reset();
        a_pulse = 0; b_pulse = 0;
        @(negedge clk); rst_n = 0;
        @(posedge clk); @(posedge clk);
        @(negedge clk); rst_n = 1;
    endtask

    // One pair of blocks with compacted magnitudes; returns block counts.
    task automatic run_pair(input int a, input int b, output int c0, output int c1);
        c0 = 0; c1 = 0;
        for (int s = 0; s < 2 * SLOTS; s++) begin
            a_pulse = ((s % SLOTS) < a);
            b_pulse = ((s % SLOTS) < b);
            #1;
            if (sum_pulse) begin
                if (s < SLOTS) c0++; else c1++;
            end
            @(posedge clk); @(negedge clk);
        end
        a_pulse = 0; b_pulse = 0;
    endtask

    // One pair with per-slot comparison against the slot ownership rule.
    task automatic run_pattern(input int a, input int b);
        for (int s = 0; s < 2 * SLOTS; s++) begin
            int  idx  = s % SLOTS;
            bit  odd  = (idx % 2 == 0);
            bit  second = (s >= SLOTS);
            bit  ain  = (idx < a);
            bit  bin  = (idx < b);
            bit  exp_p = (odd ^ second) ? ain : bin;
            a_pulse = ain; b_pulse = bin;
            #1;
            if (second) check(sum_pulse == exp_p, "R6 second-block slot", sum_pulse, exp_p);
            else        check(sum_pulse == exp_p, "R5 first-block slot", sum_pulse, exp_p);
            @(posedge clk); @(negedge clk);
        end
        a_pulse = 0; b_pulse = 0;
    endtask

    // R1 R2: every mode/sign combination, combinational response.
    task automatic test_decode();
        do_reset();
        for (int k = 0; k < 16; k++) begin
            bit ma = k[0], ms = k[1], sa = k[2], sb = k[3];
            bit ee = (ma && (sa == sb)) || (ms && (sa != sb));
            mode_add = ma; mode_sub = ms; a_sign = sa; b_sign = sb;
            #1;
            check(add_en == ee, "R1 enable decode", add_en, ee);
            check(res_sign == (ee & sa), "R2 result sign", res_sign, ee & sa);
        end
    endtask

    // R4: first slot after reset is slot 1 of a first block.
    task automatic test_reset_start();
        int c0, c1;
        mode_add = 1; mode_sub = 0; a_sign = 0; b_sign = 0;
        do_reset();
        a_pulse = 1; #1;
        check(sum_pulse == 1, "R4 slot 1 passes A after reset", sum_pulse, 1);
        a_pulse = 0;
        do_reset();
        run_pair(1, 0, c0, c1);
        check(c0 == 1, "R4 first block owns A odd", c0, 1);
        check(c1 == 0, "R4 second block swaps", c1, 0);
    endtask

    // R3: disabled path emits nothing even with full streams.
    task automatic test_disabled();
        int c0, c1;
        mode_add = 1; mode_sub = 0; a_sign = 0; b_sign = 1;
        do_reset();
        run_pair(10, 10, c0, c1);
        check(c0 + c1 == 0, "R3 add with unlike signs", c0 + c1, 0);
        mode_add = 0; mode_sub = 1; a_sign = 1; b_sign = 1;
        do_reset();
        run_pair(10, 10, c0, c1);
        check(c0 + c1 == 0, "R3 subtract with like signs", c0 + c1, 0);
        mode_add = 0; mode_sub = 0;
        do_reset();
        run_pair(7, 4, c0, c1);
        check(c0 + c1 == 0, "R3 no mode", c0 + c1, 0);
    endtask

    // R5 R6 R9: slot-accurate ownership, scattered output.
    task automatic test_pattern();
        mode_add = 1; mode_sub = 0; a_sign = 0; b_sign = 0;
        do_reset();
        run_pattern(10, 0);   // R9 pulses only in slots 1,3,..,9 then 2,4,..,10
        run_pattern(0, 10);
        run_pattern(3, 6);
        mode_add = 0; mode_sub = 1; a_sign = 0; b_sign = 1;
        run_pattern(5, 8);
    endtask

    // R7: all compacted magnitude pairs, checked per block and per pair.
    task automatic test_sweep();
        int c0, c1;
        mode_add = 1; mode_sub = 0; a_sign = 1; b_sign = 1;
        do_reset();
        check(res_sign == 1, "R2 negative like signs", res_sign, 1);
        for (int a = 0; a <= SLOTS; a++) begin
            for (int b = 0; b <= SLOTS; b++) begin
                int e0 = (a + 1) / 2 + b / 2;
                int e1 = a / 2 + (b + 1) / 2;
                run_pair(a, b, c0, c1);
                check(c0 == e0, "R7 first block count", c0, e0);
                check(c1 == e1, "R7 second block count", c1, e1);
                check(c0 + c1 == a + b, "R7 pair total", c0 + c1, a + b);
            end
        end
    endtask

    // R8: reset in the middle of a block restarts the pair.
    task automatic test_mid_reset();
        int c0, c1;
        mode_add = 1; mode_sub = 0; a_sign = 0; b_sign = 0;
        do_reset();
        for (int s = 0; s < SLOTS + 7; s++) begin
            a_pulse = 1; b_pulse = 0;
            @(posedge clk); @(negedge clk);
        end
        do_reset();
        run_pair(1, 0, c0, c1);
        check(c0 == 1, "R8 restart first block", c0, 1);
        check(c1 == 0, "R8 restart second block", c1, 0);
    endtask

    initial begin
        test_decode();
        test_reset_start();
        test_disabled();
        test_pattern();
        test_sweep();
        test_mid_reset();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule